// File: doc/BRIEF.md
# Status Register Write-Protect Guard

This block holds the protection-related bits of a serial memory's status register. These are a two-bit block-protect code and a write-protect enable bit. It decides whether a status-register write or an array write may proceed. The surrounding serial front end hands it decoded requests. The first is a status-write request carrying its data byte. The second is an array-write request carrying its target address. The front end also supplies the chip-select level, the write-protect pin, the write-enable latch and a strobe marking the start of the internal write cycle. The block answers with single-cycle verdict pulses and a readable status byte.

A status write is judged twice. It is judged first when its data byte arrives, and again on every cycle while chip select stays low. A protected pin level seen during that window cancels it. Once the internal cycle has started, the staged value is committed and the pin no longer matters. The pin only counts when the enable bit is set. Array writes are checked against the region that the block-protect code covers. The upper address bits decide whether an address falls in that region.

Top module: `statGuard`

## Requirements
- R1: After reset the enable bit and both block-protect bits are 0, the status byte reads {4'b0000, 2'b00, wel, 1'b0}, and every verdict output is low.
- R2: The status byte is laid out as bit 7 = write-protect enable, bits 3:2 = block-protect code, bit 1 = write-enable latch input, and all other bits 0. A committed status write changes only bits 7, 3 and 2, and the other data bits are discarded.
- R3: A status-write request made while the write-enable latch is low is rejected. `statReject` pulses on the cycle after the request.
- R4: A status-write request made while the enable bit is 1 and `wpN` is low is rejected on the cycle after the request.
- R5: After a request is accepted, if `wpN` is low with the enable bit at 1 on any cycle where `csN` is low and `cycleStart` is not asserted, the pending write is cancelled. `statReject` pulses one cycle later.
- R6: When `cycleStart` is asserted while a write is pending, the write commits whatever the level of `wpN`. The new bits and a `statCommit` pulse appear on the next cycle.
- R7: While the enable bit is 0, the level of `wpN` has no effect on any status-write verdict.
- R8: Block-protect code 00 protects nothing, 01 the top quarter (two address MSBs = 11), 10 the top half (address MSB = 1), and 11 the whole array. A request to a protected address gives `arrBlock` on the next cycle.
- R9: An array request gives exactly one of `arrOk` and `arrBlock` on the next cycle. `arrOk` requires the write-enable latch to be set and the address to be unprotected.
- R10: A rejected or cancelled status write leaves the status bits unchanged. `statCommit` and `statReject` never pulse together.
- R11: A pending status write whose chip select rises without `cycleStart` is dropped with a `statReject` pulse, and the status bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip-select level, active low |
| wpN | input | 1 | Write-protect pin, active low |
| wel | input | 1 | Write-enable latch state |
| statWrReq | input | 1 | Status-write data byte received (one-cycle pulse) |
| statWrData | input | 8 | Status-write data byte |
| cycleStart | input | 1 | Internal write cycle begins (one-cycle pulse) |
| arrReq | input | 1 | Array-write request (one-cycle pulse) |
| arrAddr | input | ADDR_W | Array-write target address |
| statCommit | output | 1 | Status write committed |
| statReject | output | 1 | Status write rejected, cancelled or dropped |
| arrOk | output | 1 | Array write allowed |
| arrBlock | output | 1 | Array write inhibited |
| statusByte | output | 8 | Readable status byte |

## Verification
The hardest case to reach is a write that passes its first check and is then cancelled by the pin mid-frame. That needs the enable bit committed to 1 by an earlier write, the pin high when the byte arrives, and the pin dropping before the cycle starts. The bench drives every status write as a three-phase frame with independent random pin levels for the request, middle and start phases. Frames whose data sets bit 7 arm the enable bit for the frames after them, so cancellations and pin-ignored commits both occur often. A bench model tracks the committed bits and predicts each verdict.

// File: rtl/statGuardPkg.sv
package statGuardPkg;
  localparam int WPEN_POS = 7;
  localparam int BP_HI    = 3;
  localparam int BP_LO    = 2;
  localparam int WEL_POS  = 1;

  typedef struct packed {
    logic capture;
    logic commit;
    logic reject;
  } sgStrobe_t;
endpackage

// File: rtl/statGuardCtrl.sv
module statGuardCtrl
  import statGuardPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      wpN,
  input  logic      wel,
  input  logic      statWrReq,
  input  logic      cycleStart,
  input  logic      wpenBit,
  output sgStrobe_t strb,
  output logic      statCommit,
  output logic      statReject
);
  logic pending;
  logic lockNow, commitNow, dropCs, cancelWp, reqEval, reqPass;

  always_comb begin
    lockNow   = wpenBit && !wpN;
    commitNow = pending && cycleStart;
    dropCs    = pending && !cycleStart && csN;
    cancelWp  = pending && !cycleStart && !csN && lockNow;
    reqEval   = statWrReq && !commitNow;
    reqPass   = wel && !lockNow;
    strb.capture = reqEval && reqPass;
    strb.commit  = commitNow;
    strb.reject  = dropCs || cancelWp || (reqEval && !reqPass);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending    <= 1'b0;
      statCommit <= 1'b0;
      statReject <= 1'b0;
    end else begin
      statCommit <= strb.commit;
      statReject <= strb.reject;
      if (strb.capture)
        pending <= 1'b1;
      else if (commitNow || dropCs || cancelWp)
        pending <= 1'b0;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(statCommit && statReject)); // R10
  AST_COMMIT_FROM_START: assert property (@(posedge clk) disable iff (!rstN)
    statCommit |-> $past(cycleStart)); // R6
endmodule

// File: rtl/statGuardData.sv
module statGuardData
  import statGuardPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  sgStrobe_t         strb,
  input  logic [7:0]        statWrData,
  input  logic              wel,
  input  logic              arrReq,
  input  logic [ADDR_W-1:0] arrAddr,
  output logic              wpenBit,
  output logic              arrOk,
  output logic              arrBlock,
  output logic [7:0]        statusByte
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] bp;
  logic       stageWpen;
  logic [1:0] stageBp;
  logic       inRegion;

  always_comb begin
    case (bp)
      2'b00:   inRegion = 1'b0;
      2'b01:   inRegion = &arrAddr[TOP -: 2];
      2'b10:   inRegion = arrAddr[TOP];
      default: inRegion = 1'b1;
    endcase
  end

  always_comb begin
    statusByte            = '0;
    statusByte[WPEN_POS]  = wpenBit;
    statusByte[BP_HI:BP_LO] = bp;
    statusByte[WEL_POS]   = wel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpenBit   <= 1'b0;
      bp        <= 2'b00;
      stageWpen <= 1'b0;
      stageBp   <= 2'b00;
      arrOk     <= 1'b0;
      arrBlock  <= 1'b0;
    end else begin
      if (strb.capture) begin
        stageWpen <= statWrData[WPEN_POS];
        stageBp   <= statWrData[BP_HI:BP_LO];
      end
      if (strb.commit) begin
        wpenBit <= stageWpen;
        bp      <= stageBp;
      end
      arrOk    <= arrReq && wel && !inRegion;
      arrBlock <= arrReq && !(wel && !inRegion);
    end
  end

  AST_HOLD_BITS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable({wpenBit, bp})); // R10
  AST_WHOLE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (arrReq && bp == 2'b11) |=> arrBlock); // R8
endmodule

// File: rtl/statGuard.sv
module statGuard
  import statGuardPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wpN,
  input  logic              wel,
  input  logic              statWrReq,
  input  logic [7:0]        statWrData,
  input  logic              cycleStart,
  input  logic              arrReq,
  input  logic [ADDR_W-1:0] arrAddr,
  output logic              statCommit,
  output logic              statReject,
  output logic              arrOk,
  output logic              arrBlock,
  output logic [7:0]        statusByte
);
  sgStrobe_t strb;
  logic      wpenBit;

  statGuardCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN), .wel(wel),
    .statWrReq(statWrReq), .cycleStart(cycleStart), .wpenBit(wpenBit),
    .strb(strb), .statCommit(statCommit), .statReject(statReject)
  );

  statGuardData #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .statWrData(statWrData), .wel(wel),
    .arrReq(arrReq), .arrAddr(arrAddr), .wpenBit(wpenBit),
    .arrOk(arrOk), .arrBlock(arrBlock), .statusByte(statusByte)
  );

  AST_ARR_ONE: assert property (@(posedge clk) disable iff (!rstN)
    arrReq |=> (arrOk != arrBlock)); // R9
endmodule

// File: tb/statGuard_bench.sv
module statGuard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;

  logic clk = 0, rstN = 0, csN = 1, wpN = 1, wel = 0;
  logic statWrReq = 0, cycleStart = 0, arrReq = 0;
  logic [7:0] statWrData = 0;
  logic [ADDR_W-1:0] arrAddr = 0;
  logic statCommit, statReject, arrOk, arrBlock;
  logic [7:0] statusByte;

  int nTests = 0, nFail = 0;
  logic eWpen = 0;
  logic [1:0] eBp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  statGuard #(.ADDR_W(ADDR_W)) u_statGuard (.*);

  function automatic logic [7:0] expStatus(logic w);
    return {eWpen, 3'b000, eBp, w, 1'b0};
  endfunction

  function automatic logic expProt(logic [1:0] b, logic [ADDR_W-1:0] a);
    case (b)
      2'b00:   return 1'b0;
      2'b01:   return a[ADDR_W-1] && a[ADDR_W-2];
      2'b10:   return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // status write frame: request, middle, start phase
  task automatic statSeq(logic [7:0] d, logic w, logic wpReq, logic wpMid,
                         logic wpStart, logic noStart, string req);
    logic rej;
    @(negedge clk);
    csN = 0; wel = w; wpN = wpReq; statWrReq = 1; statWrData = d;
    @(negedge clk);
    statWrReq = 0;
    rej = !w || (eWpen && !wpReq);
    check({req, " R3/R4 request verdict"}, {6'b0, statCommit, statReject}, {6'b0, 1'b0, rej});
    if (rej) begin
      csN = 1; wpN = 1;
      @(negedge clk);
      check("R10 unchanged after reject", statusByte, expStatus(w));
      return;
    end
    wpN = wpMid;
    @(negedge clk);
    rej = eWpen && !wpMid;
    check({req, " R5/R7 mid verdict"}, {6'b0, statCommit, statReject}, {6'b0, 1'b0, rej});
    if (rej) begin
      csN = 1; wpN = 1;
      @(negedge clk);
      check("R10 unchanged after cancel", statusByte, expStatus(w));
      return;
    end
    wpN = wpStart; csN = 1; cycleStart = !noStart;
    @(negedge clk);
    cycleStart = 0; wpN = 1;
    if (noStart) begin
      check("R11 dropped on CS rise", {6'b0, statCommit, statReject}, 8'h01);
    end else begin
      check({req, " R6 commit"}, {6'b0, statCommit, statReject}, 8'h02);
      eWpen = d[7]; eBp = d[3:2];
    end
    check("R2 status byte", statusByte, expStatus(w));
  endtask

  task automatic arrSeq(logic [ADDR_W-1:0] a, logic w, string req);
    logic p;
    @(negedge clk);
    arrReq = 1; arrAddr = a; wel = w;
    p = expProt(eBp, a);
    @(negedge clk);
    arrReq = 0;
    check({req, " R8/R9 array verdict"}, {6'b0, arrOk, arrBlock},
          {6'b0, w && !p, !(w && !p)});
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 reset status", statusByte, 8'h00);
    check("R1 reset verdicts", {4'b0, statCommit, statReject, arrOk, arrBlock}, 8'h00);
    rstN = 1;
    @(negedge clk);
    // directed corners
    statSeq(8'h7B, 1, 1, 1, 1, 0, "R2 junk bits");           // bp=10, wpen=0
    statSeq(8'h04, 0, 1, 1, 1, 0, "R3 no wel");
    statSeq(8'h8C, 1, 0, 0, 0, 0, "R7 wp ignored");         // wpen off: commits
    statSeq(8'h00, 1, 0, 1, 1, 0, "R4 locked at request");
    statSeq(8'h00, 1, 1, 0, 1, 0, "R5 wp falls mid");
    statSeq(8'h88, 1, 1, 1, 0, 0, "R6 wp low at start");    // bp=10 wpen=1
    statSeq(8'h04, 1, 1, 1, 1, 1, "R11 no start");
    arrSeq({2'b10, {(ADDR_W-2){1'b0}}}, 1, "R8 half");
    arrSeq({2'b01, {(ADDR_W-2){1'b1}}}, 1, "R8 lower half");
    arrSeq({2'b01, {(ADDR_W-2){1'b1}}}, 0, "R9 no wel");
    statSeq(8'h0C, 1, 1, 1, 1, 0, "R2 full lock");          // bp=11 wpen=0
    arrSeq('0, 1, "R8 whole");
    statSeq(8'h04, 1, 1, 1, 1, 0, "R2 quarter");
    arrSeq({2'b11, {(ADDR_W-2){1'b0}}}, 1, "R8 quarter hit");
    arrSeq({2'b10, {(ADDR_W-2){1'b1}}}, 1, "R8 quarter miss");
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(1, 0) == 0)
        statSeq(8'($urandom), ($urandom_range(7, 0) != 0), 1'($urandom),
                1'($urandom), 1'($urandom), ($urandom_range(9, 0) == 0), "rand");
      else
        arrSeq(ADDR_W'($urandom), ($urandom_range(3, 0) != 0), "rand");
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule